// File: doc/BRIEF.md
# Keypad Code Lock Controller

This block is the decision logic of a keyless door lock. A keypad front end, which lies outside this block, scans and debounces the keys. It sends one single-cycle strobe per key press, together with a 4-bit matrix position. The controller checks the keys against three stored 4-digit codes. The three codes share their first three digits and differ only in the last one:

- The **main code** toggles the first lock and fires a momentary pulse.
- The **auxiliary code** toggles the second lock.
- The **panic code** toggles the first lock and raises a latched alarm.

A wrong key fires a tamper pulse. A key entry must be completed within a time window, which is counted in clock cycles. The same keypad can enter a reprogramming mode that loads all three codes from one 6-digit entry.

Every result is registered and appears in the cycle after the clock edge that samples the key strobe. The time window and the pulse width are parameters counted in clock cycles.

Top module: `keylock_ctrl`

## Requirements
- R1: A key is encoded as `{row[1:0], col[1:0]}`: rows X1..X4 map to 0..3, and columns Y1..Y4 map to 0..3. A code is matched digit by digit in order. After reset the shared first three digits are 0x0, 0x1, 0x5. The last digit is 0x4 for the main code, 0x0 for the auxiliary code and 0x1 for the panic code.
- R2: Completing the main code toggles `lock1`, starts a `momentary` pulse and clears `alarm`.
- R3: Completing the auxiliary code toggles `lock2`. When the auxiliary and main last digits are equal, that entry toggles both locks and performs every main-code action.
- R4: Completing the panic code toggles `lock1` and sets `alarm`, which stays high until a main code clears it. When the panic and main last digits are equal, the main-code actions apply and `alarm` is not set.
- R5: Outside program mode, a key that does not match the digit expected at the current position starts a `tamper` pulse and restarts the entry at its first digit.
- R6: The entry window opens on the first key of an entry. A key arriving j cycles after that first key continues the entry only if j < ENTRY_CYCLES. Otherwise the entry is dropped without a tamper pulse, and that key counts as the first digit of a new entry.
- R7: After a completed auxiliary code, two presses of key 0xC (X4Y1) inside a fresh window set `prog_mode`. Any other key at that point is taken as the first digit of a new entry.
- R8: In program mode six keys are captured:
  - digits 1-4 become the main code;
  - digits 1-3 plus digit 5 become the auxiliary code;
  - digits 1-3 plus digit 6 become the panic code.
  
  Key 0xE (X4Y3) restarts the capture at digit 1. `prog_mode` clears on the sixth digit. No tamper pulse and no timeout occur in program mode.
- R9: `momentary` and `tamper` each go high for exactly PULSE_CYCLES cycles, starting in the cycle after the triggering key. A new trigger during a pulse restarts that pulse's full width.
- R10: `lock_status` is always the inverse of `lock1`. Reset leaves both locks, `alarm`, `prog_mode` and both pulses low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe per debounced key |
| key_code | input | 4 | Key position {row, col} |
| lock1 | output | 1 | First lock drive, toggling |
| lock2 | output | 1 | Second lock drive, toggling |
| lock_status | output | 1 | Inverse of lock1, for an indicator |
| alarm | output | 1 | Latched alarm request |
| momentary | output | 1 | Fixed-width pulse on a main code |
| tamper | output | 1 | Fixed-width pulse on a wrong key |
| prog_mode | output | 1 | High while new codes are being captured |

## Verification
All registered results are due one cycle after the edge that samples `key_valid`. This covers both lock levels, the alarm latch, the program flag and the rising edge of each pulse. Each pulse then falls PULSE_CYCLES edges after the trigger edge. The entry window closes on the edge ENTRY_CYCLES after the first key. The bench drives keys on falling edges and samples on the falling edge that follows the sampling edge. A cycle counter numbers each key's edge, so the reference model decides window expiry and pulse extent from exact edge numbers. The directed pulse and window tests wait a computed number of falling edges, so that the samples fall on the last high cycle and the first low cycle of each pulse, and on the last accepted edge and the first expired edge of the window.

// File: rtl/keylock_pkg.sv
package keylock_pkg;

  localparam int KEY_W      = 4;
  localparam int PREFIX_LEN = 3;
  localparam int CODE_LEN   = PREFIX_LEN + 1;
  localparam int PROG_LEN   = PREFIX_LEN + 3;

  typedef logic [KEY_W-1:0] key_t;

  // key position from matrix row (X) and column (Y), both zero based
  function automatic key_t key_at(input int unsigned row, input int unsigned col);
    return key_t'((row << (KEY_W/2)) | col);
  endfunction

  localparam key_t KEY_PROG    = key_at(3, 0);
  localparam key_t KEY_RESTART = key_at(3, 2);

  localparam key_t DEF_PFX0  = key_at(0, 0);
  localparam key_t DEF_PFX1  = key_at(0, 1);
  localparam key_t DEF_PFX2  = key_at(1, 1);
  localparam key_t DEF_MAIN  = key_at(1, 0);
  localparam key_t DEF_AUX   = key_at(0, 0);
  localparam key_t DEF_PANIC = key_at(0, 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_AUX_OK = 2'd1,
    ST_ARM1   = 2'd2,
    ST_PROG   = 2'd3
  } lock_state_e;

  typedef struct packed {
    logic any;
    logic tog1;
    logic tog2;
    logic pulse;
    logic alarm_set;
    logic alarm_clr;
    logic aux;
  } action_t;

  // decides what a completed 4th digit does
  function automatic action_t decide(input key_t k, input key_t main4,
                                     input key_t aux4, input key_t panic4);
    action_t a;
    logic hm, ha, hp;
    hm = (k == main4);
    ha = (k == aux4);
    hp = (k == panic4);
    a.any       = hm | ha | hp;
    a.tog1      = hm | hp;
    a.tog2      = ha;
    a.pulse     = hm;
    a.alarm_clr = hm;
    a.alarm_set = hp & ~hm;
    a.aux       = ha;
    return a;
  endfunction

endpackage

// File: rtl/kl_entry_timer.sv
module kl_entry_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  output logic running,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = running && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (stop || expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: an expired window closes unless a new entry reopens it
  assert_window_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> !running);

  // R6: a freshly opened window begins counting from zero
  assert_window_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && cnt == '0));

endmodule

// File: rtl/kl_pulse_gen.sv
module kl_pulse_gen #(
  parameter int WIDTH = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)             left <= '0;
    else if (trig)          left <= CW'(WIDTH);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign pulse = (left != '0);

  // R9: a trigger makes the pulse high in the next cycle
  assert_pulse_starts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pulse);

  // R9: the last counted cycle ends the pulse when no retrigger comes
  assert_pulse_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (left == CW'(1) && !trig) |=> !pulse);

endmodule

// File: rtl/kl_code_store.sv
module kl_code_store
  import keylock_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             prog_active,
  input  logic                             key_valid,
  input  key_t                             key,
  output logic [PREFIX_LEN-1:0][KEY_W-1:0] prefix,
  output key_t                             main4,
  output key_t                             aux4,
  output key_t                             panic4,
  output logic                             prog_done
);
  localparam int IW = $clog2(PROG_LEN);

  logic [IW-1:0]                     idx;
  logic [PROG_LEN-2:0][KEY_W-1:0]    cap;
  logic                              restart;

  assign restart   = prog_active && key_valid && (key == KEY_RESTART);
  assign prog_done = prog_active && key_valid && !restart && (idx == IW'(PROG_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      cap    <= '0;
      prefix <= {DEF_PFX2, DEF_PFX1, DEF_PFX0};
      main4  <= DEF_MAIN;
      aux4   <= DEF_AUX;
      panic4 <= DEF_PANIC;
    end else if (!prog_active || restart) begin
      idx <= '0;
    end else if (prog_done) begin
      prefix <= cap[PREFIX_LEN-1:0];
      main4  <= cap[PREFIX_LEN];
      aux4   <= cap[PREFIX_LEN+1];
      panic4 <= key;
      idx    <= '0;
    end else if (key_valid) begin
      cap[idx] <= key;
      idx      <= idx + 1'b1;
    end
  end

  // R8: the sixth captured key becomes the panic digit
  assert_sixth_digit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (panic4 == $past(key)));

  // R8: the capture pointer never passes the last digit
  assert_idx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IW'(PROG_LEN));

endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int ENTRY_CYCLES = 50000,
  parameter int PULSE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [3:0] key_code,
  output logic       lock1,
  output logic       lock2,
  output logic       lock_status,
  output logic       alarm,
  output logic       momentary,
  output logic       tamper,
  output logic       prog_mode
);
  localparam int PTR_W = $clog2(CODE_LEN);
  localparam int NPULSE = 2;

  lock_state_e st, eff_st, st_nxt;
  logic [PTR_W-1:0] ptr, eff_ptr, ptr_nxt;

  logic [PREFIX_LEN-1:0][KEY_W-1:0] prefix;
  key_t main4, aux4, panic4, exp_digit, key;
  logic prog_done;

  logic tmr_start, tmr_stop, tmr_running, tmr_expire;
  logic normal, at_last, digit_ok, code_hit, tamper_trig;
  logic arm_step, enter_prog, waiting_arm;
  action_t act;

  logic [NPULSE-1:0] pulse_trig, pulse_out;

  assign key = key_t'(key_code);

  kl_code_store u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_active(st == ST_PROG),
    .key_valid  (key_valid),
    .key        (key),
    .prefix     (prefix),
    .main4      (main4),
    .aux4       (aux4),
    .panic4     (panic4),
    .prog_done  (prog_done)
  );

  kl_entry_timer #(.LIMIT(ENTRY_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .stop   (tmr_stop),
    .running(tmr_running),
    .expire (tmr_expire)
  );

  // window expiry takes effect in the same cycle as any arriving key
  always_comb begin
    eff_st  = tmr_expire ? ST_IDLE : st;
    eff_ptr = tmr_expire ? '0 : ptr;
    exp_digit = prefix[0];
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (eff_ptr == PTR_W'(i)) exp_digit = prefix[i];
    end
    waiting_arm = (eff_st == ST_AUX_OK) || (eff_st == ST_ARM1);
    normal      = key_valid && ((eff_st == ST_IDLE) || (waiting_arm && key != KEY_PROG));
    at_last     = (eff_ptr == PTR_W'(PREFIX_LEN));
    act         = decide(key, main4, aux4, panic4);
    digit_ok    = normal && !at_last && (key == exp_digit);
    code_hit    = normal && at_last && act.any;
    tamper_trig = normal && !digit_ok && !code_hit;
    arm_step    = key_valid && waiting_arm && (key == KEY_PROG);
    enter_prog  = arm_step && (eff_st == ST_ARM1);
    tmr_start   = (digit_ok && eff_ptr == '0) || (code_hit && act.aux);
    tmr_stop    = tamper_trig || (code_hit && !act.aux) || enter_prog;
  end

  always_comb begin
    st_nxt  = eff_st;
    ptr_nxt = eff_ptr;
    if (enter_prog)                       st_nxt = ST_PROG;
    else if (arm_step)                    st_nxt = ST_ARM1;
    else if (st == ST_PROG && prog_done)  st_nxt = ST_IDLE;
    else if (code_hit)                    st_nxt = act.aux ? ST_AUX_OK : ST_IDLE;
    else if (normal)                      st_nxt = ST_IDLE;
    if (digit_ok)     ptr_nxt = eff_ptr + 1'b1;
    else if (normal)  ptr_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      ptr   <= '0;
      lock1 <= 1'b0;
      lock2 <= 1'b0;
      alarm <= 1'b0;
    end else begin
      st  <= st_nxt;
      ptr <= ptr_nxt;
      if (code_hit) begin
        lock1 <= lock1 ^ act.tog1;
        lock2 <= lock2 ^ act.tog2;
        if (act.alarm_clr)      alarm <= 1'b0;
        else if (act.alarm_set) alarm <= 1'b1;
      end
    end
  end

  assign pulse_trig = {tamper_trig, code_hit && act.pulse};

  for (genvar g = 0; g < NPULSE; g++) begin : g_pulse
    kl_pulse_gen #(.WIDTH(PULSE_CYCLES)) u_pulse (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (pulse_trig[g]),
      .pulse(pulse_out[g])
    );
  end

  assign momentary   = pulse_out[0];
  assign tamper      = pulse_out[1];
  assign prog_mode   = (st == ST_PROG);
  assign lock_status = ~lock1;

  // R8: the entry window is never open while codes are being captured
  assert_prog_no_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> !tmr_running);

  // R7: program mode begins only on a press of the program key
  assert_prog_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> $past(key_valid && key_code == KEY_PROG));

  // R4: the alarm latch rises only in response to a key
  assert_alarm_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(key_valid));

  // R3: the second lock holds its level when no key arrives
  assert_lock2_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(key_valid) |-> $stable(lock2));

  // R5: a rejected key restarts the digit pointer
  assert_ptr_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_trig |=> (ptr == '0));

endmodule

// File: tb/keylock_ctrl_test.sv
`timescale 1ns/1ps
module keylock_ctrl_test;
  localparam int ENTRY = 40;
  localparam int PW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic [3:0] key_code = 4'h0;
  logic lock1, lock2, lock_status, alarm, momentary, tamper, prog_mode;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  logic [3:0] m_pre [3];
  logic [3:0] m_p4, m_s4, m_d4;
  logic [3:0] m_buf [6];
  int m_st, m_ptr, m_idx, m_t0, m_mom, m_tam;
  bit m_tact, m_l1, m_l2, m_al, m_prog;

  keylock_ctrl #(.ENTRY_CYCLES(ENTRY), .PULSE_CYCLES(PW)) uut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .lock1(lock1), .lock2(lock2), .lock_status(lock_status), .alarm(alarm),
    .momentary(momentary), .tamper(tamper), .prog_mode(prog_mode));

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic bit pulse_on(input int s, input int e);
    return (e >= s) && (e < s + PW);
  endfunction

  task automatic model_reset();
    m_pre[0] = 4'h0; m_pre[1] = 4'h1; m_pre[2] = 4'h5;
    m_p4 = 4'h4; m_s4 = 4'h0; m_d4 = 4'h1;
    m_st = 0; m_ptr = 0; m_idx = 0; m_tact = 0; m_t0 = 0;
    m_mom = -1000; m_tam = -1000;
    m_l1 = 0; m_l2 = 0; m_al = 0; m_prog = 0;
  endtask

  task automatic model_key(input logic [3:0] k, input int e);
    bit hp, hs, hd;
    if (m_tact && (e - m_t0 >= ENTRY)) begin
      m_st = 0; m_ptr = 0; m_tact = 0;
    end
    if (m_st == 3) begin
      if (k == 4'hE) m_idx = 0;
      else begin
        m_buf[m_idx] = k;
        m_idx++;
        if (m_idx == 6) begin
          m_pre[0] = m_buf[0]; m_pre[1] = m_buf[1]; m_pre[2] = m_buf[2];
          m_p4 = m_buf[3]; m_s4 = m_buf[4]; m_d4 = m_buf[5];
          m_st = 0; m_prog = 0; m_idx = 0;
        end
      end
    end else if (m_st == 1 && k == 4'hC) begin
      m_st = 2;
    end else if (m_st == 2 && k == 4'hC) begin
      m_st = 3; m_prog = 1; m_tact = 0; m_idx = 0;
    end else begin
      m_st = 0;
      if (m_ptr < 3) begin
        if (k == m_pre[m_ptr]) begin
          if (m_ptr == 0) begin m_tact = 1; m_t0 = e; end
          m_ptr++;
        end else begin
          m_tam = e; m_ptr = 0; m_tact = 0;
        end
      end else begin
        hp = (k == m_p4); hs = (k == m_s4); hd = (k == m_d4);
        m_ptr = 0;
        if (!(hp || hs || hd)) begin
          m_tam = e; m_tact = 0;
        end else begin
          if (hp || hd) m_l1 = !m_l1;
          if (hs) m_l2 = !m_l2;
          if (hp) begin m_mom = e; m_al = 0; end
          else if (hd) m_al = 1;
          if (hs) begin m_st = 1; m_tact = 1; m_t0 = e; end
          else m_tact = 0;
        end
      end
    end
  endtask

  task automatic check_all(input int e);
    chk(lock1, m_l1, "R2 lock1");
    chk(lock2, m_l2, "R3 lock2");
    chk(alarm, m_al, "R4 alarm");
    chk(tamper, pulse_on(m_tam, e), "R5 tamper");
    chk(prog_mode, m_prog, "R7 prog_mode");
    chk(momentary, pulse_on(m_mom, e), "R9 momentary");
    chk(lock_status, !m_l1, "R10 lock_status");
  endtask

  task automatic press(input logic [3:0] k);
    int e;
    @(negedge clk);
    key_valid = 1'b1; key_code = k; e = cyc + 1;
    model_key(k, e);
    @(negedge clk);
    key_valid = 1'b0;
    check_all(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter4(input logic [3:0] a, b, c, d);
    press(a); press(b); press(c); press(d);
  endtask

  task automatic program6(input logic [3:0] a, b, c, d, e5, f);
    press(a); press(b); press(c); press(d); press(e5); press(f);
  endtask

  task automatic random_key(output logic [3:0] k);
    int r;
    r = $urandom_range(0, 9);
    if (m_st == 3) k = (r == 0) ? 4'hE : 4'($urandom_range(0, 13));
    else if (r < 6) begin
      if (m_ptr < 3) k = m_pre[m_ptr];
      else begin
        r = $urandom_range(0, 2);
        k = (r == 0) ? m_p4 : (r == 1) ? m_s4 : m_d4;
      end
    end else if (r < 8) k = 4'hC;
    else k = 4'($urandom_range(0, 15));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic old1, old2;
    logic [3:0] k;
    void'($urandom(32'd20240));
    model_reset();
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    chk(lock1, 1'b0, "R10 reset lock1");
    chk(lock2, 1'b0, "R10 reset lock2");
    chk(lock_status, 1'b1, "R10 reset lock_status");
    chk(alarm, 1'b0, "R10 reset alarm");
    chk(prog_mode, 1'b0, "R10 reset prog_mode");
    chk(momentary, 1'b0, "R10 reset momentary");
    chk(tamper, 1'b0, "R10 reset tamper");

    // R1 default main code, R9 pulse width
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    chk(lock1, 1'b1, "R1 default main code toggles lock1");
    chk(momentary, 1'b1, "R2 momentary starts");
    idle(PW - 1);
    chk(momentary, 1'b1, "R9 momentary last high cycle");
    idle(1);
    chk(momentary, 1'b0, "R9 momentary width");

    // R6 silent timeout
    press(4'h0); press(4'h1);
    idle(ENTRY + 2);
    chk(tamper, 1'b0, "R6 timeout is silent");
    press(4'h5);
    chk(tamper, 1'b1, "R6 pointer restarted after timeout");
    idle(PW + 1);

    // R6 last accepted edge
    old1 = lock1;
    press(4'h0); press(4'h1); press(4'h5);
    idle(ENTRY - 7);
    press(4'h4);
    chk(lock1, !old1, "R6 key at window edge minus one accepted");
    idle(PW + 1);
    // R6 first expired edge
    old1 = lock1;
    press(4'h0); press(4'h1); press(4'h5);
    idle(ENTRY - 6);
    press(4'h4);
    chk(tamper, 1'b1, "R6 key at window limit rejected");
    chk(lock1, old1, "R6 lock1 held after expiry");
    idle(PW + 1);

    // R5 and R9 tamper retrigger
    press(4'h7);
    chk(tamper, 1'b1, "R5 wrong first key");
    press(4'h7);
    idle(PW - 1);
    chk(tamper, 1'b1, "R9 retrigger extends tamper");
    idle(1);
    chk(tamper, 1'b0, "R9 retriggered tamper ends");

    // R4 panic code, R2 clears alarm
    old1 = lock1;
    enter4(4'h0, 4'h1, 4'h5, 4'h1);
    chk(alarm, 1'b1, "R4 panic sets alarm");
    chk(lock1, !old1, "R4 panic toggles lock1");
    chk(momentary, 1'b0, "R4 no momentary on panic");
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    chk(alarm, 1'b0, "R2 main code clears alarm");

    // R7 other key after auxiliary code starts a new entry
    old2 = lock2;
    enter4(4'h0, 4'h1, 4'h5, 4'h0);
    chk(lock2, !old2, "R3 auxiliary toggles lock2");
    press(4'h0);
    chk(tamper, 1'b0, "R7 key after auxiliary taken as first digit");
    old1 = lock1;
    press(4'h1); press(4'h5); press(4'h4);
    chk(lock1, !old1, "R7 entry after auxiliary completes");
    idle(PW + 1);

    // R7/R8 program mode
    enter4(4'h0, 4'h1, 4'h5, 4'h0);
    press(4'hC);
    chk(prog_mode, 1'b0, "R7 one program key is not enough");
    press(4'hC);
    chk(prog_mode, 1'b1, "R7 program mode entered");
    idle(ENTRY + 5);
    chk(prog_mode, 1'b1, "R8 no timeout in program mode");
    press(4'h3); press(4'h7); press(4'h9);
    chk(tamper, 1'b0, "R8 no tamper in program mode");
    press(4'hE);
    press(4'h2); press(4'h3); press(4'h6); press(4'h8); press(4'hA);
    chk(prog_mode, 1'b1, "R8 still capturing before sixth digit");
    press(4'hB);
    chk(prog_mode, 1'b0, "R8 program flag clears on sixth digit");
    old1 = lock1;
    enter4(4'h2, 4'h3, 4'h6, 4'h8);
    chk(lock1, !old1, "R8 new main code");
    enter4(4'h2, 4'h3, 4'h6, 4'hB);
    chk(alarm, 1'b1, "R8 new panic code");
    old2 = lock2;
    enter4(4'h2, 4'h3, 4'h6, 4'hA);
    chk(lock2, !old2, "R8 new auxiliary code");

    // R3 equal last digits for auxiliary and main
    press(4'hC); press(4'hC);
    program6(4'h1, 4'h2, 4'h3, 4'h4, 4'h4, 4'h5);
    idle(PW + 1);
    old1 = lock1; old2 = lock2;
    enter4(4'h1, 4'h2, 4'h3, 4'h4);
    chk(lock1, !old1, "R3 shared digit toggles lock1");
    chk(lock2, !old2, "R3 shared digit toggles lock2");
    chk(momentary, 1'b1, "R3 shared digit fires momentary");
    chk(alarm, 1'b0, "R3 shared digit clears alarm");

    // R4 panic digit equal to main digit: main wins
    press(4'hC); press(4'hC);
    program6(4'h0, 4'h1, 4'h5, 4'h4, 4'h0, 4'h4);
    old1 = lock1;
    enter4(4'h0, 4'h1, 4'h5, 4'h4);
    chk(lock1, !old1, "R4 equal digits toggle lock1 once");
    chk(alarm, 1'b0, "R4 equal digits do not set alarm");

    // constrained random run against the model
    for (int i = 0; i < 600; i++) begin
      random_key(k);
      press(k);
      if ($urandom_range(0, 29) == 0) idle(ENTRY + $urandom_range(0, 4));
      else idle($urandom_range(0, 3));
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule